// File: doc/BRIEF.md
# Byte-Lane Static RAM Sequencer

This block sits between a synchronous request port and an external asynchronous static RAM of 32,768 sixteen-bit words. A requester offers an operation with a valid/ready handshake. Each operation carries a write flag, a 15-bit word address, 16 bits of write data and a two-bit lane mask. The sequencer converts the operation into the memory's active-low strobes: chip select, write strobe, output enable, and one enable for each byte lane. It holds them for a number of clock cycles set by parameters. A read result comes back with a one-cycle valid pulse.

Every operation takes a fixed number of cycles and always passes through an idle cycle. In that cycle the memory is deselected, its outputs are disabled and the sequencer's own drivers are off. This gives the bus a turnaround gap, so the two sides never drive the data lines together. A write stores its data when the write strobe rises. The sequencer keeps its data on the bus for one further cycle after that rising edge. The data bus appears as three separate signals: an output word, an input word and a drive enable for the pad.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, every active-low memory strobe (`mem_ce_n`, `mem_we_n`, `mem_oe_n`, `mem_lb_n`, `mem_ub_n`) is 1. `mem_dq_oe` and `rsp_valid` are 0, and `req_ready` is 1.
- R2: A read accepted at a clock edge gives exactly RD_CYCLES cycles starting with the next cycle. In those cycles `mem_ce_n`=0, `mem_oe_n`=0, `mem_we_n`=1 and `mem_dq_oe`=0, and `mem_addr` equals the accepted address.
- R3: While an operation runs, lane-mask bit 0 drives `mem_lb_n` low and bit 1 drives `mem_ub_n` low. A clear mask bit keeps its enable at 1. When `mem_ce_n` is 1, both enables are 1.
- R4: Read data is sampled at the clock edge that ends the last read cycle. In the cycle that follows, `rsp_valid` is 1 for exactly one cycle. In `rsp_rdata`, bits 7:0 belong to mask bit 0 and bits 15:8 to mask bit 1, and a lane whose mask bit is clear reads as zero.
- R5: A write accepted at an edge gives WR_CYCLES cycles with `mem_ce_n`=0, `mem_we_n`=0, `mem_oe_n`=1 and `mem_dq_oe`=1, with `mem_dq_o` equal to the write data. One more cycle follows with `mem_we_n`=1 and `mem_ce_n`=0, and the same data still driven.
- R6: `mem_dq_oe` is never 1 while `mem_oe_n` is 0, and `mem_oe_n` is never 0 while `mem_we_n` is 0.
- R7: `req_ready` is 0 from the cycle after an acceptance until the operation ends. After a read it returns to 1 RD_CYCLES+1 cycles after the accepting edge. After a write it returns to 1 WR_CYCLES+2 cycles after that edge.
- R8: In every cycle with `req_ready`=1, the memory is in standby: `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1 and `mem_dq_oe` is 0. A write that directly follows a read therefore sees at least one cycle with output enable high before the drivers turn on.
- R9: An operation with an all-zero lane mask runs the full sequence with both byte enables at 1. A read of this kind returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operation offered |
| req_ready | output | 1 | Sequencer idle, operation may be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 16 | Write data |
| req_lanes | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | Read result valid, one-cycle pulse |
| rsp_rdata | output | 16 | Read result, unselected lanes zero |
| mem_addr | output | 15 | Memory address bus |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_dq_o | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_i | input | 16 | Data received from the memory |

## Verification
All memory strobes are registered, so they change in the first cycle after the accepting edge. A read result appears RD_CYCLES+1 cycles after acceptance, and `req_ready` returns to 1 in that same cycle. After a write, `req_ready` returns WR_CYCLES+2 cycles after acceptance, and the stored data becomes visible to a later read. At each acceptance the bench queues one expected frame for every cycle the operation will take. It compares one frame against the outputs at each falling edge, so every result is checked in the cycle in which it is due. A behavioural memory model on the bench stores bytes when the write strobe rises and returns filler on unselected lanes, which shows that the zeroing of those lanes is observed.

// File: rtl/srlc_pkg.sv
package srlc_pkg;
    localparam int ADDR_W = 15;
    localparam int DATA_W = 16;
    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2,
        PH_WHOLD = 2'd3
    } phase_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic drive;
    } strobe_t;

    function automatic strobe_t strobe_of(phase_e ph);
        strobe_t s;
        case (ph)
            PH_READ:  s = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b0, drive: 1'b0};
            PH_WRITE: s = '{ce_n: 1'b0, we_n: 1'b0, oe_n: 1'b1, drive: 1'b1};
            PH_WHOLD: s = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1, drive: 1'b1};
            default:  s = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
        endcase
        return s;
    endfunction
endpackage

// File: rtl/srlc_seq.sv
module srlc_seq
    import srlc_pkg::*;
#(
    parameter int RD_CYCLES = 2,
    parameter int WR_CYCLES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    accept,
    input  logic    acc_write,
    output phase_e  phase_q,
    output phase_e  phase_d,
    output strobe_t strobe_q,
    output logic    capture
);
    localparam int MAXC = (RD_CYCLES > WR_CYCLES) ? RD_CYCLES : WR_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] RD_LOAD = CW'(RD_CYCLES - 1);
    localparam logic [CW-1:0] WR_LOAD = CW'(WR_CYCLES - 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        capture = 1'b0;
        case (phase_q)
            PH_IDLE: begin
                if (accept) begin
                    phase_d = acc_write ? PH_WRITE : PH_READ;
                    cnt_d   = acc_write ? WR_LOAD : RD_LOAD;
                end
            end
            PH_READ: begin
                if (cnt_q == '0) begin
                    phase_d = PH_IDLE;
                    capture = 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            PH_WRITE: begin
                if (cnt_q == '0) phase_d = PH_WHOLD;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            cnt_q    <= '0;
            strobe_q <= strobe_of(PH_IDLE);
        end else begin
            phase_q  <= phase_d;
            cnt_q    <= cnt_d;
            strobe_q <= strobe_of(phase_d);
        end
    end
endmodule

// File: rtl/srlc_lanes.sv
module srlc_lanes
    import srlc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              active_d,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_lanes,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [LANES-1:0]  be_n_q,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    logic [LANES-1:0] lanes_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q    <= '0;
            wdata_q   <= '0;
            lanes_q   <= '0;
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= capture;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                lanes_q <= req_lanes;
            end
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic sel;
        assign sel = accept ? req_lanes[g] : lanes_q[g];

        always_ff @(posedge clk) begin
            if (rst) begin
                be_n_q[g]                     <= 1'b1;
                rsp_rdata[g*LANE_W +: LANE_W] <= '0;
            end else begin
                be_n_q[g] <= !(active_d && sel);
                if (capture)
                    rsp_rdata[g*LANE_W +: LANE_W] <=
                        lanes_q[g] ? mem_dq_i[g*LANE_W +: LANE_W] : '0;
            end
        end
    end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import srlc_pkg::*;
#(
    parameter int RD_CYCLES = 2,
    parameter int WR_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_lanes,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    phase_e         phase_q, phase_d;
    strobe_t        strobe_q;
    logic           capture;
    logic           accept;
    logic [LANES-1:0] be_n_q;

    assign req_ready = (phase_q == PH_IDLE);
    assign accept    = req_valid && req_ready;

    srlc_seq #(.RD_CYCLES(RD_CYCLES), .WR_CYCLES(WR_CYCLES)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .acc_write(req_write),
        .phase_q  (phase_q),
        .phase_d  (phase_d),
        .strobe_q (strobe_q),
        .capture  (capture)
    );

    srlc_lanes u_lanes (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .active_d (phase_d != PH_IDLE),
        .capture  (capture),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .req_lanes(req_lanes),
        .mem_dq_i (mem_dq_i),
        .addr_q   (mem_addr),
        .wdata_q  (mem_dq_o),
        .be_n_q   (be_n_q),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata)
    );

    assign mem_ce_n  = strobe_q.ce_n;
    assign mem_we_n  = strobe_q.we_n;
    assign mem_oe_n  = strobe_q.oe_n;
    assign mem_dq_oe = strobe_q.drive;
    assign mem_lb_n  = be_n_q[0];
    assign mem_ub_n  = be_n_q[1];
endmodule

// File: rtl/srlc_checker.sv
module srlc_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        mem_ce_n,
    input logic        mem_we_n,
    input logic        mem_oe_n,
    input logic        mem_lb_n,
    input logic        mem_ub_n,
    input logic [15:0] mem_dq_o,
    input logic        mem_dq_oe
);
    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> mem_oe_n); // R6
    AST_OE_WE_APART: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n); // R6
    AST_READ_STROBES: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (!mem_ce_n && mem_we_n && !mem_dq_oe)); // R2
    AST_LANES_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        mem_ce_n |-> (mem_lb_n && mem_ub_n)); // R3
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R4
    AST_WE_RISE_HOLDS_DATA: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n && $stable(mem_dq_o))); // R5
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready); // R7
    AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe)); // R8
endmodule

bind sram_lane_ctrl srlc_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .mem_ce_n (mem_ce_n),
    .mem_we_n (mem_we_n),
    .mem_oe_n (mem_oe_n),
    .mem_lb_n (mem_lb_n),
    .mem_ub_n (mem_ub_n),
    .mem_dq_o (mem_dq_o),
    .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_lane_ctrl_bench.sv
`timescale 1ns/1ps
module sram_lane_ctrl_bench;
    localparam int RD = 2;
    localparam int WR = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_lanes = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [14:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n;
    logic [15:0] mem_dq_o;
    logic        mem_dq_oe;
    logic [15:0] mem_dq_i;

    always #10 clk = ~clk;

    sram_lane_ctrl #(.RD_CYCLES(RD), .WR_CYCLES(WR)) u_sram_lane_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_lanes(req_lanes), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural asynchronous memory on the bench side
    logic [15:0] sram    [0:32767];
    logic [15:0] exp_mem [0:32767];

    always_comb begin
        if (!mem_ce_n && !mem_oe_n && mem_we_n)
            mem_dq_i = {mem_ub_n ? 8'hEE : sram[mem_addr][15:8],
                        mem_lb_n ? 8'hEE : sram[mem_addr][7:0]};
        else
            mem_dq_i = 16'hBEEF;
    end

    always @(posedge mem_we_n) begin
        if (!rst && !mem_ce_n) begin
            chk("R5 data driven at strobe rise", {31'd0, mem_dq_oe}, 32'd1);
            if (!mem_lb_n) sram[mem_addr][7:0]  = mem_dq_o[7:0];
            if (!mem_ub_n) sram[mem_addr][15:8] = mem_dq_o[15:8];
        end
    end

    typedef struct packed {
        logic [1:0]  kind;   // 0 idle, 1 read, 2 write, 3 write hold
        logic        ce, we, oe, drv, lb, ub, rdy, rv, nolane;
        logic [15:0] rdata;
        logic [14:0] addr;
        logic [15:0] wd;
    } frame_t;

    frame_t q[$];
    frame_t idle_f;

    task automatic push_op(input bit wr, input logic [14:0] a, input logic [15:0] d,
                           input logic [1:0] ln);
        frame_t f;
        f = idle_f;
        f.ce = 1'b0; f.lb = !ln[0]; f.ub = !ln[1]; f.rdy = 1'b0; f.addr = a;
        if (!wr) begin
            f.kind = 2'd1; f.oe = 1'b0;
            for (int i = 0; i < RD; i++) q.push_back(f);
            f = idle_f;
            f.rv = 1'b1;
            f.nolane = (ln == 2'b00);
            f.rdata = {ln[1] ? exp_mem[a][15:8] : 8'h00, ln[0] ? exp_mem[a][7:0] : 8'h00};
            q.push_back(f);
        end else begin
            f.kind = 2'd2; f.we = 1'b0; f.drv = 1'b1; f.wd = d;
            for (int i = 0; i < WR; i++) q.push_back(f);
            f.kind = 2'd3; f.we = 1'b1;
            q.push_back(f);
            q.push_back(idle_f);
            if (ln[0]) exp_mem[a][7:0]  = d[7:0];
            if (ln[1]) exp_mem[a][15:8] = d[15:8];
        end
    endtask

    function automatic string ctl_tag(input logic [1:0] k);
        case (k)
            2'd1:    return "R2 read strobes";
            2'd2:    return "R5 write strobes";
            2'd3:    return "R5 write hold";
            default: return "R8 idle standby";
        endcase
    endfunction

    // scripted operations: write flag, address, data, lanes
    localparam int NSCR = 9;
    logic        s_wr  [NSCR] = '{1, 0, 1, 0, 1, 0, 0, 0, 1};
    logic [14:0] s_a   [NSCR] = '{15'h0010, 15'h0010, 15'h0010, 15'h0010, 15'h7FFF,
                                  15'h7FFF, 15'h7FFF, 15'h0000, 15'h0000};
    logic [15:0] s_d   [NSCR] = '{16'hA1B2, 16'h0, 16'h3344, 16'h0, 16'h55AA,
                                  16'h0, 16'h0, 16'h0, 16'h1357};
    logic [1:0]  s_ln  [NSCR] = '{2'b11, 2'b11, 2'b01, 2'b11, 2'b10,
                                  2'b10, 2'b00, 2'b01, 2'b00};

    initial begin
        frame_t f;
        int     issued;
        for (int a = 0; a < 32768; a++) begin
            sram[a]    = 16'(a * 40503) ^ 16'h1234;
            exp_mem[a] = 16'(a * 40503) ^ 16'h1234;
        end
        idle_f = '{kind: 2'd0, ce: 1'b1, we: 1'b1, oe: 1'b1, drv: 1'b0, lb: 1'b1,
                   ub: 1'b1, rdy: 1'b1, rv: 1'b0, nolane: 1'b0, rdata: '0,
                   addr: '0, wd: '0};
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state held during reset
        chk("R1 strobes in reset", {27'd0, mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 32'h1F);
        chk("R1 drive and rsp in reset", {30'd0, mem_dq_oe, rsp_valid}, 32'd0);
        chk("R1 ready in reset", {31'd0, req_ready}, 32'd1);
        rst = 1'b0;
        issued = 0;
        while (issued < NSCR + 240 || q.size() > 0) begin
            @(negedge clk);
            f = (q.size() > 0) ? q.pop_front() : idle_f;
            chk(ctl_tag(f.kind), {28'd0, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe},
                {28'd0, f.ce, f.we, f.oe, f.drv});
            chk("R3 byte enables", {30'd0, mem_ub_n, mem_lb_n}, {30'd0, f.ub, f.lb});
            chk("R7 ready", {31'd0, req_ready}, {31'd0, f.rdy});
            chk("R4 rsp_valid", {31'd0, rsp_valid}, {31'd0, f.rv});
            if (f.rv)
                chk(f.nolane ? "R9 empty-lane read data" : "R4 read data",
                    {16'd0, rsp_rdata}, {16'd0, f.rdata});
            if (!f.ce) chk("R2 address held", {17'd0, mem_addr}, {17'd0, f.addr});
            if (f.drv) chk("R5 write data", {16'd0, mem_dq_o}, {16'd0, f.wd});
            chk("R6 no bus contention",
                {31'd0, mem_dq_oe && !mem_ce_n && !mem_oe_n && mem_we_n}, 32'd0);
            req_valid = 1'b0;
            req_write = $urandom_range(0, 1);
            req_addr  = 15'($urandom);
            req_wdata = 16'($urandom);
            req_lanes = 2'($urandom);
            if (q.size() == 0 && issued < NSCR + 240) begin
                if (issued < NSCR) begin
                    req_valid = 1'b1;
                    req_write = s_wr[issued];
                    req_addr  = s_a[issued];
                    req_wdata = s_d[issued];
                    req_lanes = s_ln[issued];
                end else if ($urandom_range(0, 3) != 0) begin
                    req_valid = 1'b1;
                    req_addr  = 15'($urandom_range(0, 15));
                end
                if (req_valid) begin
                    push_op(req_write, req_addr, req_wdata, req_lanes);
                    issued++;
                end
            end
        end
        repeat (2) @(negedge clk);
        chk("R8 final standby", {29'd0, mem_ce_n, mem_oe_n, mem_dq_oe}, 32'h6);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule